// File: doc/BRIEF.md
# Pipelined Wide-Word CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a stream of 64-bit words and takes one word on every clock. Each update is split into two parts. One part depends only on the incoming word and is worked out over two registered stages. The other part depends only on the current 32-bit check register and stays within a single cycle. An XOR merges the two parts just ahead of the check register. As a result, the feedback loop stays about as shallow as a 32-bit-wide update, however wide the data bus is.

A producer marks each word with a valid bit. The first word of a message also carries a first marker, and the closing word carries a last marker. Two clocks after the last word passes through the pipeline, the block presents the finished check value for one cycle, with a valid pulse. A new message may follow the last word of the previous one with no idle cycle in between.

Top module: `crc_wide_pipe`

## Requirements
- R1: While reset is applied and after it is released, `crc_out` reads 0 and `crc_valid` reads 0 until the first result.
- R2: The check uses generator 0x04C11DB7. The register is seeded with all ones. The bits of each word are shifted in from bit 63 down to bit 0, with no reflection. The presented value is the bitwise inverse of the register. The result equals that of a bit-at-a-time shift register fed the same bits.
- R3: Words marked valid on consecutive clocks are all absorbed, one per clock, with no stall and no ready signal.
- R4: A valid word with `in_first` set restarts the register from the all-ones seed and discards any unfinished message.
- R5: Clocks with `in_valid` low leave the check register and the result unchanged, so idle gaps inside a message do not alter its result.
- R6: If the last word of a message is sampled at rising edge n, `crc_valid` is high for exactly the one cycle following rising edge n+2. No message yields more or fewer than one result.
- R7: While `crc_valid` is low, `crc_out` holds the most recent result.
- R8: A message whose first word follows the previous message's last word on the very next clock produces a result that depends on its own words only.
- R9: `in_first` and `in_last` have no effect on clocks where `in_valid` is low.
- R10: A valid word without `in_first` that follows a finished message continues from the register left by that message. The next result then covers both messages joined together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies the word and markers on this clock |
| in_first | input | 1 | Word opens a new message (seed the register) |
| in_last | input | 1 | Word closes the message (present a result) |
| in_data | input | 64 | Data word, bit 63 shifted first |
| crc_out | output | 32 | Inverted check value of the latest finished message |
| crc_valid | output | 1 | One-cycle pulse marking a new value on `crc_out` |

## Verification
The hardest case to reach from the ports is a word in the delayed data pipeline meeting a state that changed in the same cycle. Examples are a new first word arriving right behind a last word, or a restart in the middle of a message while earlier words are still in flight. The stimulus produces these cases with directed sequences: a restart mid-message, a continuation after a finished message, and idle gaps carrying stray markers. It then runs many random-length messages, mostly back to back, with occasional random gaps. Every result is compared with a bit-serial model in the bench, and the exact cycle each result appears is also checked.

// File: rtl/crc_wide_pkg.sv
package crc_wide_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef logic [CRC_W-1:0] crc_t;

  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } word_tag_t;

  // One step of the serial shift register, MSB-first, no reflection.
  function automatic crc_t lfsr_bit(input crc_t s, input logic b);
    logic fb;
    fb = s[CRC_W-1] ^ b;
    return {s[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n_o = sync_q[1];
endmodule

// File: rtl/crc_tag_delay.sv
module crc_tag_delay
  import crc_wide_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid_i,
  input  logic      first_i,
  input  logic      last_i,
  output logic      mid_valid_o,
  output word_tag_t tag_o
);
  word_tag_t entry;
  word_tag_t stage_d [DEPTH];
  word_tag_t stage_q [DEPTH];

  // Markers only count when the word is valid.
  always_comb begin
    entry.valid = valid_i;
    entry.first = valid_i & first_i;
    entry.last  = valid_i & last_i;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage_d[k] = entry;
    end else begin : g_body
      assign stage_d[k] = stage_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_d[k];
    end
  end

  assign mid_valid_o = stage_q[0].valid;
  assign tag_o       = stage_q[DEPTH-1];

  assert_markers_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!stage_q[0].first && !stage_q[0].last));
endmodule

// File: rtl/crc_data_term.sv
module crc_data_term
  import crc_wide_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SEGMENTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load1_i,
  input  logic              load2_i,
  input  logic [DATA_W-1:0] data_i,
  output crc_t              term_o
);
  localparam int SEG_W = DATA_W / SEGMENTS;

  // Register contribution of a single set data bit, starting from zero state.
  function automatic crc_t data_col(input int idx);
    crc_t s;
    s = '0;
    for (int k = DATA_W - 1; k >= 0; k--) s = lfsr_bit(s, (k == idx));
    return s;
  endfunction

  function automatic logic [SEG_W-1:0] seg_mask(input int seg, input int row);
    logic [SEG_W-1:0] m;
    crc_t c;
    for (int b = 0; b < SEG_W; b++) begin
      c    = data_col(seg * SEG_W + b);
      m[b] = c[row];
    end
    return m;
  endfunction

  logic [SEGMENTS-1:0][CRC_W-1:0] part_d, part_q;
  crc_t fold_d, term_q;

  // Stage 1: partial XOR per data segment.
  for (genvar sg = 0; sg < SEGMENTS; sg++) begin : g_seg
    for (genvar r = 0; r < CRC_W; r++) begin : g_row
      localparam logic [SEG_W-1:0] MASK = seg_mask(sg, r);
      assign part_d[sg][r] = ^(data_i[sg*SEG_W +: SEG_W] & MASK);
    end
  end

  // Stage 2: fold the partials together.
  always_comb begin
    fold_d = '0;
    for (int sg = 0; sg < SEGMENTS; sg++) fold_d = fold_d ^ part_q[sg];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      term_q <= '0;
    end else begin
      if (load1_i) part_q <= part_d;
      if (load2_i) term_q <= fold_d;
    end
  end

  assign term_o = term_q;

  assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load1_i && data_i == '0) |=> (part_q == '0));
endmodule

// File: rtl/crc_state_term.sv
module crc_state_term
  import crc_wide_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  crc_t state_i,
  output crc_t term_o
);
  // Register after DATA_W zero-bit shifts from a single set state bit.
  function automatic crc_t state_col(input int idx);
    crc_t s;
    s      = '0;
    s[idx] = 1'b1;
    for (int k = 0; k < DATA_W; k++) s = lfsr_bit(s, 1'b0);
    return s;
  endfunction

  function automatic crc_t row_mask(input int row);
    crc_t m;
    crc_t c;
    for (int j = 0; j < CRC_W; j++) begin
      c    = state_col(j);
      m[j] = c[row];
    end
    return m;
  endfunction

  for (genvar r = 0; r < CRC_W; r++) begin : g_row
    localparam crc_t MASK = row_mask(r);
    assign term_o[r] = ^(state_i & MASK);
  end
endmodule

// File: rtl/crc_wide_pipe.sv
module crc_wide_pipe
  import crc_wide_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SEGMENTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_valid
);
  localparam int PIPE_DEPTH = 2;

  logic      srst_n;
  logic      mid_valid;
  word_tag_t tag_at_state;
  crc_t      data_term, state_base, state_term, merged;
  crc_t      state_d, state_q, res_d, res_q;
  logic      vld_d, vld_q;

  crc_rst_sync u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  crc_tag_delay #(.DEPTH(PIPE_DEPTH)) u_tags (
    .clk         (clk),
    .rst_n       (srst_n),
    .valid_i     (in_valid),
    .first_i     (in_first),
    .last_i      (in_last),
    .mid_valid_o (mid_valid),
    .tag_o       (tag_at_state)
  );

  crc_data_term #(.DATA_W(DATA_W), .SEGMENTS(SEGMENTS)) u_data (
    .clk     (clk),
    .rst_n   (srst_n),
    .load1_i (in_valid),
    .load2_i (mid_valid),
    .data_i  (in_data),
    .term_o  (data_term)
  );

  crc_state_term #(.DATA_W(DATA_W)) u_state (
    .state_i (state_base),
    .term_o  (state_term)
  );

  // Next-state logic.
  always_comb begin
    state_base = tag_at_state.first ? CRC_SEED : state_q;
    merged     = state_term ^ data_term;
    state_d    = tag_at_state.valid ? merged : state_q;
    vld_d      = tag_at_state.valid & tag_at_state.last;
    res_d      = vld_d ? ~merged : res_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= CRC_SEED;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
    end
  end

  assign crc_out   = res_q;
  assign crc_valid = vld_q;

  assert_idle_holds_state_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(in_valid, 3) |-> $stable(state_q));

  assert_result_timing_R6: assert property (@(posedge clk) disable iff (!srst_n)
    crc_valid |-> $past(in_valid && in_last, 3));

  assert_output_holds_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !crc_valid |-> $stable(crc_out));
endmodule

// File: tb/crc_wide_pipe_test.sv
module crc_wide_pipe_test;
  localparam logic [31:0] SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic [63:0] in_data = '0;
  logic [31:0] crc_out;
  logic        crc_valid;

  always #5 clk = ~clk;

  crc_wide_pipe uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_data   (in_data),
    .crc_out   (crc_out),
    .crc_valid (crc_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] ref_st = SEED;
  logic [31:0] exp_q[$];
  int          exp_cyc_q[$];
  string       exp_tag_q[$];
  logic [31:0] prev_out = '0;
  logic        mon_on = 1'b0;

  function automatic logic [31:0] ref_word(input logic [31:0] s, input logic [63:0] w);
    logic fb;
    for (int k = 63; k >= 0; k--) begin
      fb = s[31] ^ w[k];
      s  = {s[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w, input bit f, input bit l, input int gap,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_first = f;
    in_last  = l;
    in_data  = w;
    if (f) ref_st = SEED;
    ref_st = ref_word(ref_st, w);
    if (l) begin
      exp_q.push_back(~ref_st);
      exp_cyc_q.push_back(cyc + 3);
      exp_tag_q.push_back(tag);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'($urandom % 2);  // R9: stray markers while idle
      in_last  = 1'($urandom % 2);
      in_data  = {$urandom, $urandom};
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // Result monitor, sampling away from the rising edge.
  always @(negedge clk) begin
    if (mon_on) begin
      if (crc_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected result", crc_out, 32'h0);
        end else begin
          logic [31:0] e;
          int          ec;
          string       t;
          e  = exp_q.pop_front();
          ec = exp_cyc_q.pop_front();
          t  = exp_tag_q.pop_front();
          check(crc_out == e, t, crc_out, e);
          check(cyc == ec, "R6 result cycle", cyc, ec);
        end
      end else begin
        check(crc_out == prev_out, "R7 output held", crc_out, prev_out);
      end
      prev_out = crc_out;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(crc_valid == 1'b0, "R1 valid in reset", {31'b0, crc_valid}, 32'h0);
    check(crc_out == 32'h0, "R1 output in reset", crc_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(crc_valid == 1'b0, "R1 valid after reset", {31'b0, crc_valid}, 32'h0);
    check(crc_out == 32'h0, "R1 output after reset", crc_out, 32'h0);
    prev_out = crc_out;
    mon_on   = 1'b1;

    // Directed corner cases
    send(64'h0, 1, 1, 0, "R2 all-zero word");
    send('1, 1, 1, 2, "R2 R8 all-ones word");
    send(64'h0123_4567_89AB_CDEF, 1, 0, 3, "R5 R9 gapped message");
    send(64'hFEDC_BA98_7654_3210, 0, 0, 1, "R5 R9 gapped message");
    send(64'h8000_0000_0000_0001, 0, 1, 4, "R5 R9 gapped message");
    send(64'hDEAD_BEEF_CAFE_F00D, 1, 0, 0, "R4 restart");
    send(64'h1111_2222_3333_4444, 0, 0, 0, "R4 restart");
    send(64'hA5A5_5A5A_0F0F_F0F0, 1, 0, 0, "R4 restart");
    send(64'h0000_FFFF_0000_FFFF, 0, 1, 0, "R4 restart");
    send(64'h1357_9BDF_2468_ACE0, 1, 1, 0, "R10 head message");
    send(64'h0F1E_2D3C_4B5A_6978, 0, 0, 0, "R10 continuation");
    send(64'h8877_6655_4433_2211, 0, 1, 2, "R10 continuation");
    idle(3);

    // Long back-to-back message: one word per clock
    for (int k = 0; k < 12; k++)
      send({$urandom, $urandom}, k == 0, k == 11, 0, "R3 streaming");

    // Random messages, mostly back to back
    for (int m = 0; m < 60; m++) begin
      int len;
      len = 1 + int'($urandom % 8);
      for (int k = 0; k < len; k++) begin
        int gap;
        gap = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
        send({$urandom, $urandom}, k == 0, k == len - 1, gap, "R2 R8 random");
      end
    end

    idle(8);
    check(exp_q.size() == 0, "R6 missing result", exp_q.size(), 32'h0);
    summary();
    $finish;
  end
endmodule